// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a register-mapped watchdog. A watchdog clock enable (`wdt_tick`) drives a fixed divide-by-32 prescaler, and its carries feed a postscaler counter whose terminal count is a power of two chosen by a 5-bit control field. While the timer is enabled and the count reaches its end, the block raises a one-cycle reset request, sets a sticky cause flag and starts counting again from zero. Software prevents this by writing a 16-bit service key as a halfword into the upper half of the control word. Each such write restarts the count.

An optional windowed mode tightens the servicing rule. A key written before the last quarter of the period counts as a fault and trips the watchdog at once. A key written inside the last quarter is accepted. The control and status registers each have a plain address, a bit-clear alias and a bit-set alias. The 2-bit clock-select field is stored and read back only.

The sequencer has three states. `ST_OFF` moves to `ST_COUNT` when the enable bit is 1. `ST_COUNT` returns to `ST_OFF` when the enable is cleared. It moves to `ST_TRIP` when the count expires without an accepted key in the same cycle, or when an early key arrives in windowed mode. `ST_TRIP` lasts one cycle and then goes to `ST_COUNT` if the timer is still enabled, otherwise to `ST_OFF`.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0, the status word (offset 0x10) reads 0, and `rst_req` is low.
- R2: Control word layout: bit 15 is the enable, bit 0 selects windowed mode, bits 7:6 hold the clock-select code and bits 12:8 the postscaler value `ps`. All of these read back as written, and every other bit reads 0.
- R3: Writing to the control word at offset 0x08 ORs the byte-masked data into it. Writing at offset 0x04 clears the bits that are 1 in the byte-masked data. No other bit changes.
- R4: With `wdt_tick` held high and no service key, the first `rst_req` pulse comes `(32<<ps)+1` cycles after the write edge that sets the enable.
- R5: `rst_req` is high for exactly one cycle per timeout, and the count restarts from zero, so free-running pulses are `(32<<ps)+1` cycles apart.
- R6: A write to word 0 with byte strobes `4'b1100` and data bits 31:16 equal to 16'h5743 restarts the count. If no further key follows, the next pulse comes `32<<ps` cycles after that write edge.
- R7: A halfword write to word 0 carrying any other upper value is ignored, and so is a full-word write (strobes `4'b1111`) even if it carries the key. Neither changes when the next pulse comes.
- R8: While the enable is 0, nothing counts and no pulse is produced, and a key write has no effect.
- R9: Each timeout sets status bit 4 and keeps it set. Software clears it by writing 0x10 at offset 0x14. Offset 0x18 sets status bits.
- R10: In windowed mode, a key arriving while the tick position within the period is below three quarters of `32<<ps` produces a pulse on the next cycle. A key arriving at or after that point is accepted as in R6.
- R11: Status bits 2 and 3 change only through software writes to the status word and its aliases. Every status bit other than 2, 3 and 4 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdt_tick | input | 1 | Watchdog clock enable; each high cycle is one watchdog tick |
| bus_valid | input | 1 | Bus write request qualifier |
| bus_write | input | 1 | 1 = write access |
| bus_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| bus_be | input | 4 | Byte strobes for the 32-bit data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The pulse times follow from the registers on the path. An enable write takes effect at edge k. The sequencer enters counting at k+1 and the first increment happens at k+2. The first pulse therefore appears in the cycle after edge k+1+(32<<ps), and an accepted key at edge j gives a pulse after edge j+(32<<ps). An early windowed key at edge j gives its pulse after edge j itself.

The driver computes each due cycle from these rules and queues it before it issues the stimulus. The monitor samples `rst_req` on falling edges against a free-running edge count and pops the queue. Any pulse that is unqueued or arrives in the wrong cycle is a failure, and so is any entry still left in the queue at the end.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_TRIP  = 2'd2
    } wd_state_t;

    localparam logic [15:0] KICK_KEY   = 16'h5743;
    localparam int          EN_BIT     = 15;
    localparam int          WIN_BIT    = 0;
    localparam int          CS_LSB     = 6;
    localparam int          PS_LSB     = 8;
    localparam int          CAUSE_BIT  = 4;
    localparam logic [15:0] CTRL_MASK  = 16'h9FC1;
    localparam logic [31:0] STAT_MASK  = 32'h0000_001C;
endpackage

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         carry
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    assign carry = tick && (cnt == {W{1'b1}});
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int PRE_W = 5,
    parameter int PS_W  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            expire,
    output logic            win_open
);
    localparam int POST_W = 2 ** PS_W;
    localparam int POS_W  = POST_W + PRE_W;
    localparam int SH_W   = $clog2(POS_W);

    logic [PRE_W-1:0]  pre_q;
    logic              pre_carry;
    logic [POST_W-1:0] post_q;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  limit;
    logic [POS_W-1:0]  thresh;
    logic [SH_W-1:0]   shamt;

    kwdt_prescale #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clr   (clr),
        .cnt   (pre_q),
        .carry (pre_carry)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          post_q <= '0;
        else if (clr)        post_q <= '0;
        else if (pre_carry)  post_q <= post_q + 1'b1;
    end

    assign pos    = {post_q, pre_q};
    assign shamt  = SH_W'(ps) + SH_W'(PRE_W);
    assign limit  = POS_W'(1) << shamt;
    assign thresh = limit - (limit >> 2);

    assign expire   = tick && (pos == (limit - 1'b1));
    assign win_open = (pos >= thresh);

    // R4: the position never runs past the terminal count
    p_pos_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= limit);

    // R6: a restart leaves the count at zero
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pos == '0));
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter logic [4:0]  RESET_PS = 5'd0,
    parameter logic [1:0]  RESET_CS = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              trip_set,
    output logic              en,
    output logic              win_en,
    output logic [4:0]        ps,
    output logic              kick
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [15:0] CTRL_RST =
        (16'(RESET_PS) << PS_LSB) | (16'(RESET_CS) << CS_LSB);

    logic [15:0]      ctrl_q, ctrl_d;
    logic [31:0]      stat_q, stat_d;
    logic [IDX_W-1:0] idx;
    logic [31:0]      bm, wm;
    logic             wr;

    assign idx = bus_addr[ADDR_W-1:2];
    assign wr  = bus_valid && bus_write;
    assign bm  = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
    assign wm  = bus_wdata & bm;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            case (idx)
                IDX_W'(0): ctrl_d = ((ctrl_q & ~bm[15:0]) | wm[15:0]) & CTRL_MASK;
                IDX_W'(1): ctrl_d = ctrl_q & ~wm[15:0];
                IDX_W'(2): ctrl_d = (ctrl_q | wm[15:0]) & CTRL_MASK;
                default:   ctrl_d = ctrl_q;
            endcase
        end
    end

    always_comb begin
        stat_d = stat_q;
        if (wr) begin
            case (idx)
                IDX_W'(4): stat_d = ((stat_q & ~bm) | wm) & STAT_MASK;
                IDX_W'(5): stat_d = stat_q & ~wm;
                IDX_W'(6): stat_d = (stat_q | wm) & STAT_MASK;
                default:   stat_d = stat_q;
            endcase
        end
        if (trip_set) stat_d[CAUSE_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST & CTRL_MASK;
            stat_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
        end
    end

    always_comb begin
        case (idx)
            IDX_W'(0), IDX_W'(1), IDX_W'(2): bus_rdata = {16'h0, ctrl_q};
            IDX_W'(4), IDX_W'(5), IDX_W'(6): bus_rdata = stat_q;
            default:                         bus_rdata = '0;
        endcase
    end

    assign en     = ctrl_q[EN_BIT];
    assign win_en = ctrl_q[WIN_BIT];
    assign ps     = ctrl_q[PS_LSB +: 5];
    assign kick   = wr && (idx == '0) && (bus_be == 4'b1100) &&
                    (bus_wdata[31:16] == KICK_KEY);

    // R9: a timeout leaves the cause flag set
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trip_set |=> stat_q[CAUSE_BIT]);

    // R11: unused status bits never become 1
    p_status_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~STAT_MASK) == '0);
endmodule

// File: rtl/kwdt_fsm.sv
module kwdt_fsm
    import kwdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic win_en,
    input  logic kick,
    input  logic expire,
    input  logic win_open,
    output logic rst_req,
    output logic cnt_clr
);
    wd_state_t state_q, state_d;
    logic      kick_ok, kick_early;

    assign kick_ok    = (state_q == ST_COUNT) && kick && (!win_en || win_open);
    assign kick_early = (state_q == ST_COUNT) && kick && win_en && !win_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = en ? ST_COUNT : ST_OFF;
            ST_COUNT: begin
                if (!en)                                  state_d = ST_OFF;
                else if (kick_early || (expire && !kick_ok)) state_d = ST_TRIP;
                else                                      state_d = ST_COUNT;
            end
            ST_TRIP:  state_d = en ? ST_COUNT : ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    always_comb begin
        rst_req = 1'b0;
        cnt_clr = 1'b1;
        unique case (state_q)
            ST_OFF:   cnt_clr = 1'b1;
            ST_COUNT: cnt_clr = kick_ok;
            ST_TRIP:  begin
                rst_req = 1'b1;
                cnt_clr = 1'b1;
            end
            default:  cnt_clr = 1'b1;
        endcase
    end

    // R5: the request is a single-cycle pulse
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8: a disabled timer stays quiet
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rst_req);

    // R10: an early windowed key trips at once
    p_early_trip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && win_en && kick && !win_open && state_q == ST_COUNT) |=> rst_req);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
    parameter int         ADDR_W   = 5,
    parameter int         PRE_W    = 5,
    parameter logic [4:0] RESET_PS = 5'd0,
    parameter logic [1:0] RESET_CS = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdt_tick,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req
);
    logic       en, win_en, kick, expire, win_open, cnt_clr;
    logic [4:0] ps;

    kwdt_regs #(
        .ADDR_W   (ADDR_W),
        .RESET_PS (RESET_PS),
        .RESET_CS (RESET_CS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .trip_set  (rst_req),
        .en        (en),
        .win_en    (win_en),
        .ps        (ps),
        .kick      (kick)
    );

    kwdt_counter #(.PRE_W(PRE_W), .PS_W(5)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (wdt_tick),
        .clr      (cnt_clr),
        .ps       (ps),
        .expire   (expire),
        .win_open (win_open)
    );

    kwdt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .win_en   (win_en),
        .kick     (kick),
        .expire   (expire),
        .win_open (win_open),
        .rst_req  (rst_req),
        .cnt_clr  (cnt_clr)
    );
endmodule

// File: tb/tb_kwdt_top.sv
`timescale 1ns/1ps
module tb_kwdt_top;
    typedef struct {
        int    at;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt_tick = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    int   pulses = 0;
    exp_t exp_q[$];

    kwdt_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdt_tick  (wdt_tick),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pulses are popped from the scoreboard
    always @(negedge clk) begin
        if (rst_n && rst_req) begin
            pulses++;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL unexpected pulse: actual cycle %0d expected none", cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.at != cyc) begin
                    failures++;
                    $display("FAIL %s pulse: actual cycle %0d expected %0d", e.req, cyc, e.at);
                end
            end
        end
    end

    task automatic expect_pulse(input int at, input string req);
        exp_t e;
        e.at = at;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // writes at the next edge; returns that edge's number
    task automatic wr(input logic [4:0] a, input logic [3:0] be,
                      input logic [31:0] d, output int k);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        k = cyc;
        bus_valid = 1'b0; bus_write = 1'b0; bus_be = '0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s read 0x%02h: actual 0x%08h expected 0x%08h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int k, j, j2, j3, j4, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(5'h00, 32'h0, "R1");
        rd_chk(5'h10, 32'h0, "R1");
        chk_bit(rst_req, 1'b0, "R1");

        // R2 field readback; R8 disabled timer produces nothing
        wr(5'h00, 4'b0011, 32'hFFFF_7FFE, k);
        rd_chk(5'h00, 32'h0000_1FC0, "R2");
        wr(5'h00, 4'b1100, 32'h5743_0000, k);
        p0 = pulses;
        repeat (100) @(negedge clk);
        checks++;
        if (pulses != p0) begin
            failures++;
            $display("FAIL R8 disabled pulses: actual %0d expected 0", pulses - p0);
        end

        // R4/R5 free-running with ps=0
        wr(5'h00, 4'b0011, 32'h0000_0000, k);
        expect_pulse(cyc + 1 + 33, "R4");
        expect_pulse(cyc + 1 + 66, "R5");
        wr(5'h00, 4'b0011, 32'h0000_8000, k);
        wait_to(k + 70);
        wr(5'h04, 4'b0011, 32'h0000_8000, k);   // R3 clear alias stops it
        rd_chk(5'h00, 32'h0, "R3");
        rd_chk(5'h10, 32'h10, "R9");
        wr(5'h14, 4'b0001, 32'h10, k);
        rd_chk(5'h10, 32'h0, "R9");

        // R3 set alias enable with ps=1; R7 ignored writes; R6 key
        wr(5'h00, 4'b0011, 32'h0000_0100, k);
        expect_pulse(cyc + 1 + 65, "R4");
        expect_pulse(cyc + 1 + 164, "R6");
        wr(5'h08, 4'b0011, 32'h0000_8000, k);
        rd_chk(5'h00, 32'h0000_8100, "R3");
        wait_to(k + 19);
        wr(5'h00, 4'b1100, 32'h5744_0000, j);   // R7 wrong key
        wait_to(k + 29);
        wr(5'h00, 4'b1111, 32'h5743_8100, j);   // R7 full word
        wait_to(k + 99);
        wr(5'h00, 4'b1100, 32'h5743_0000, j);   // R6 key at k+100
        wait_to(k + 170);
        wr(5'h04, 4'b0011, 32'h0000_8000, k);
        rd_chk(5'h00, 32'h0000_0100, "R3");

        // R10 windowed mode, ps=0
        wr(5'h00, 4'b0011, 32'h0000_0001, k);
        wr(5'h08, 4'b0011, 32'h0000_8000, k);
        j = k + 10;
        expect_pulse(j, "R10");
        wait_to(j - 1);
        wr(5'h00, 4'b1100, 32'h5743_0000, k);   // early: pos 8
        j2 = j + 28;
        wait_to(j2 - 1);
        wr(5'h00, 4'b1100, 32'h5743_0000, k);   // pos 26 accepted
        j3 = j2 + 24;
        expect_pulse(j3, "R10");
        wait_to(j3 - 1);
        wr(5'h00, 4'b1100, 32'h5743_0000, k);   // pos 23 early
        j4 = j3 + 26;
        wait_to(j4 - 1);
        wr(5'h00, 4'b1100, 32'h5743_0000, k);   // pos 24 accepted
        wait_to(j4 + 5);
        wr(5'h04, 4'b0011, 32'h0000_8000, k);
        repeat (40) @(negedge clk);

        // R11 status bits 2 and 3 via aliases
        wr(5'h14, 4'b0001, 32'h10, k);
        wr(5'h18, 4'b1111, 32'hFFFF_FFFF, k);
        rd_chk(5'h10, 32'h0000_001C, "R11");
        wr(5'h14, 4'b0001, 32'h04, k);
        rd_chk(5'h10, 32'h0000_0018, "R11");
        wr(5'h10, 4'b1111, 32'h0, k);
        rd_chk(5'h10, 32'h0, "R11");
        repeat (5) @(negedge clk);

        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            failures++;
            $display("FAIL %s missing pulse: actual none expected cycle %0d", e.req, e.at);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule